// File: doc/BRIEF.md
# Data operand address generator

This block produces the 9-bit data-space address of an instruction operand for a small 8-bit CPU. In direct mode the full address arrives with the request and is handed straight back, valid in the same cycle. In register-indirect mode the block first reads a one-byte pointer from a bank of sixteen pointer locations at the bottom of data RAM. It then builds the final address from that byte and the top bit of the 2-bit selector.

The pointer location is formed from the two bank bits of the status word and the selector. The bank bits pick a group of four locations, and the selector picks one location within that group. The byte read from that location becomes the low eight address bits. Selector bit 1 becomes address bit 8, so selectors 0 and 1 reach general RAM and selectors 2 and 3 reach the special function register page. A region flag reports which of the two pages the result lies in. A busy flag covers the indirect lookup, and requests are taken only while the block is idle.

Top module: `opnd_agu`

## Requirements
- R1: Out of reset, busy, ea_valid and mem_rd_en are all 0.
- R2: A direct request (req_indirect=0) taken while idle raises ea_valid in the same cycle with ea_addr equal to req_daddr. It issues no memory read and leaves busy at 0.
- R3: An indirect request (req_indirect=1) taken while idle raises mem_rd_en in the same cycle. The read address has bits 8:4 at zero, bits 3:2 equal to psw_bank and bits 1:0 equal to req_sel.
- R4: The memory returns data in the cycle after mem_rd_en. The block raises ea_valid for exactly one cycle, two cycles after the accepting cycle. At that point ea_addr[7:0] equals the returned byte.
- R5: For an indirect result, ea_addr[8] equals bit 1 of the selector given with the request.
- R6: ea_is_sfr is 1 whenever ea_valid is high and the address lies in 0x100 to 0x1FF, and 0 when it lies in 0x000 to 0x0FF. In other words, the flag follows ea_addr[8].
- R7: busy is 1 in the two cycles that follow an indirect accept and 0 otherwise. A request presented while busy is 1 is ignored: it causes no read, no extra ea_valid pulse and no change to the result in progress.
- R8: Changing psw_bank or req_sel after the accepting cycle has no effect on the lookup in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_indirect | input | 1 | 1 = register-indirect, 0 = direct |
| req_daddr | input | 9 | Direct operand address |
| req_sel | input | 2 | Indirect pointer selector |
| psw_bank | input | 2 | Pointer bank bits from the status word |
| mem_rd_en | output | 1 | Pointer read strobe |
| mem_rd_addr | output | 9 | Pointer read address |
| mem_rd_data | input | 8 | Pointer byte, one cycle after the strobe |
| ea_valid | output | 1 | Effective address valid |
| ea_addr | output | 9 | Effective address |
| ea_is_sfr | output | 1 | 1 = SFR page, 0 = RAM page |
| busy | output | 1 | Indirect lookup in progress |

## Verification
A stuck or skipped state in the lookup sequencer shows up at the ports within three cycles of an indirect accept. The symptoms are an ea_valid pulse in the wrong cycle, a missing pulse, or busy staying high. A fault in capturing the selector's top bit or the returned pointer byte shows up in the one cycle when ea_valid is high, as a wrong ea_addr or a wrong region flag. The bench moves the bank bits and the selector while a lookup is in flight, and it presents requests while the block is busy. This separates values that were sampled correctly from values that are taken live.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_DONE = 2'd2
  } agu_state_t;
endpackage

// File: rtl/agu_ctrl.sv
module agu_ctrl
  import agu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       req_indirect,
  output logic       acc_dir,
  output logic       acc_ind,
  output logic       cap_en,
  output logic       done,
  output logic       busy
);
  agu_state_t state_q, state_d;
  logic       idle;

  assign idle    = (state_q == ST_IDLE);
  assign acc_dir = idle && req_valid && !req_indirect;
  assign acc_ind = idle && req_valid && req_indirect;
  assign cap_en  = (state_q == ST_WAIT);
  assign done    = (state_q == ST_DONE);
  assign busy    = !idle;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (acc_ind) state_d = ST_WAIT;
      ST_WAIT: state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // R7: an indirect accept is followed by two busy cycles
  p_busy_after_acc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ind |=> (busy && !done));
  // R4: the wait cycle always leads to the completing cycle
  p_wait_to_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> done);
  p_done_to_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
endmodule

// File: rtl/agu_ptr_addr.sv
module agu_ptr_addr #(
  parameter int ADDR_W = 9,
  parameter int SEL_W  = 2,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [BANK_W-1:0] bank,
  input  logic [SEL_W-1:0]  sel,
  output logic [ADDR_W-1:0] rd_addr
);
  localparam int PTR_W = BANK_W + SEL_W;

  assign rd_addr = {{(ADDR_W-PTR_W){1'b0}}, bank, sel};

  // R3: pointer reads never leave the pointer window at the bottom of RAM
  p_ptr_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (rd_addr < ADDR_W'(1 << PTR_W)));
endmodule

// File: rtl/agu_ea_form.sv
module agu_ea_form #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_ind,
  input  logic              cap_en,
  input  logic              done,
  input  logic [SEL_W-1:0]  sel,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [ADDR_W-1:0] daddr,
  output logic [ADDR_W-1:0] ea
);
  logic              page_q, page_d;
  logic [DATA_W-1:0] ptr_q, ptr_d;

  always_comb begin
    page_d = page_q;
    if (acc_ind) page_d = sel[SEL_W-1];
    ptr_d = ptr_q;
    if (cap_en) ptr_d = rd_data;
  end

  always_ff @(posedge clk) begin
    page_q <= page_d;
    ptr_q  <= ptr_d;
  end

  assign ea = done ? {page_q, ptr_q} : daddr;

  // R5: the page bit of a completed indirect result was fixed at accept
  p_page_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> (ea[ADDR_W-1] == $past(page_q)));
endmodule

// File: rtl/opnd_agu.sv
module opnd_agu #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8,
  parameter int SEL_W  = 2,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_indirect,
  input  logic [ADDR_W-1:0] req_daddr,
  input  logic [SEL_W-1:0]  req_sel,
  input  logic [BANK_W-1:0] psw_bank,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              ea_valid,
  output logic [ADDR_W-1:0] ea_addr,
  output logic              ea_is_sfr,
  output logic              busy
);
  logic acc_dir, acc_ind, cap_en, done;

  agu_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_indirect(req_indirect),
    .acc_dir(acc_dir), .acc_ind(acc_ind), .cap_en(cap_en), .done(done), .busy(busy)
  );

  agu_ptr_addr #(.ADDR_W(ADDR_W), .SEL_W(SEL_W), .BANK_W(BANK_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .rd_en(acc_ind), .bank(psw_bank), .sel(req_sel),
    .rd_addr(mem_rd_addr)
  );

  agu_ea_form #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_ea (
    .clk(clk), .rst_n(rst_n), .acc_ind(acc_ind), .cap_en(cap_en), .done(done),
    .sel(req_sel), .rd_data(mem_rd_data), .daddr(req_daddr), .ea(ea_addr)
  );

  assign mem_rd_en = acc_ind;
  assign ea_valid  = acc_dir || done;
  assign ea_is_sfr = ea_addr[ADDR_W-1];

  // R7: a pointer read is issued only while idle
  p_read_when_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> !busy);
  // R4: the result appears two cycles after the pointer read
  p_valid_timing_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> ##1 ea_valid);
  // R2: a direct result never coincides with a pointer read
  p_dir_no_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ea_valid && !busy) |-> !mem_rd_en);
endmodule

// File: tb/opnd_agu_bench.sv
module opnd_agu_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid, req_indirect;
  logic [8:0] req_daddr;
  logic [1:0] req_sel, psw_bank;
  logic       mem_rd_en, ea_valid, ea_is_sfr, busy;
  logic [8:0] mem_rd_addr, ea_addr;
  logic [7:0] mem_rd_data;
  logic [7:0] ptr_mem [16];
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  opnd_agu u_opnd_agu (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_indirect(req_indirect),
    .req_daddr(req_daddr), .req_sel(req_sel), .psw_bank(psw_bank),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .ea_valid(ea_valid), .ea_addr(ea_addr), .ea_is_sfr(ea_is_sfr), .busy(busy)
  );

  always_ff @(posedge clk)
    if (mem_rd_en) mem_rd_data <= ptr_mem[mem_rd_addr[3:0]];

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_in();
    req_valid = 0; req_indirect = 0; req_daddr = '0; req_sel = '0;
  endtask

  task automatic t_reset();
    chk("R1 busy", 16'(busy), 0);
    chk("R1 ea_valid", 16'(ea_valid), 0);
    chk("R1 mem_rd_en", 16'(mem_rd_en), 0);
  endtask

  task automatic t_direct(input logic [8:0] a);
    @(negedge clk);
    req_valid = 1; req_indirect = 0; req_daddr = a;
    #1;
    chk("R2 valid", 16'(ea_valid), 1);
    chk("R2 addr", 16'(ea_addr), 16'(a));
    chk("R2 no read", 16'(mem_rd_en), 0);
    chk("R6 region", 16'(ea_is_sfr), 16'(a[8]));
    @(negedge clk);
    idle_in();
    #1 chk("R2 busy", 16'(busy), 0);
  endtask

  // indirect lookup; disturb=1 changes bank/sel and requests during busy (R7, R8)
  task automatic t_indirect(input logic [1:0] bk, input logic [1:0] s, input bit disturb);
    logic [8:0] exp;
    exp = {s[1], ptr_mem[{bk, s}]};
    @(negedge clk);
    req_valid = 1; req_indirect = 1; req_sel = s; psw_bank = bk;
    #1;
    chk("R3 rd_en", 16'(mem_rd_en), 1);
    chk("R3 rd_addr", 16'(mem_rd_addr), 16'({5'b0, bk, s}));
    chk("R4 not yet", 16'(ea_valid), 0);
    @(negedge clk);
    if (disturb) begin
      psw_bank = ~bk; req_sel = ~s; req_indirect = 0; req_daddr = 9'h1AA;
    end else idle_in();
    #1;
    chk("R7 busy1", 16'(busy), 1);
    chk("R7 ignore rd", 16'(mem_rd_en), 0);
    chk("R7 ignore valid", 16'(ea_valid), 0);
    @(negedge clk);
    if (disturb) begin req_indirect = 1; req_sel = ~s; end
    #1;
    chk("R7 busy2", 16'(busy), 1);
    chk("R4 valid", 16'(ea_valid), 1);
    chk("R4 low byte", 16'(ea_addr[7:0]), 16'(exp[7:0]));
    chk(disturb ? "R8 held addr" : "R5 page", 16'(ea_addr[8]), 16'(exp[8]));
    chk("R6 region", 16'(ea_is_sfr), 16'(exp[8]));
    chk("R7 ignore rd2", 16'(mem_rd_en), 0);
    @(negedge clk);
    idle_in();
    #1;
    chk("R4 one pulse", 16'(ea_valid), 0);
    chk("R7 idle", 16'(busy), 0);
  endtask

  initial begin
    #150000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) ptr_mem[i] = 8'(8'h3C ^ (i * 8'h17));
    rst_n = 0; idle_in(); psw_bank = 0;
    repeat (3) @(posedge clk);
    #1 t_reset();
    @(negedge clk); rst_n = 1;
    #1 t_reset();
    t_direct(9'h045);
    t_direct(9'h1F3);
    for (int b = 0; b < 4; b++)
      for (int s = 0; s < 4; s++)
        t_indirect(2'(b), 2'(s), 1'b0);
    t_indirect(2'd2, 2'd1, 1'b1);
    t_indirect(2'd1, 2'd3, 1'b1);
    t_direct(9'h100);
    t_direct(9'h0FF);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule